// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a DDR2-style SDRAM on every rising clock edge and turns each sampled pin pattern into a one-cycle command strobe. The strobes cover activate, read, write, precharge, mode register set and refresh. The block keeps an open/closed flag and a latched row address for each bank. For every read or write it reports the target bank, the starting column and whether auto-precharge was asked for.

The block also holds the burst length that a mode register command programs. It uses that length to time auto-precharge closes. It checks that the clock-enable pin stays high while a burst is in flight. When clock-enable drops, it labels the power-down as active or precharge, depending on whether any row is open. Protocol misuse is latched in sticky error flags. These cover a read or write to a closed bank, an activate to a bank that is already open, and clock-enable dropped inside a burst.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted and after its release with no command, every strobe and error flag is 0, all banks are closed, all row registers are 0, both power-down flags are 0 and the burst length is four (`bl8_o` = 0).
- R2: With CKE high and CS_n low, {RAS_n,CAS_n,WE_n} = 011 activate, 101 read, 100 write, 010 precharge, 000 mode register set, 001 refresh; 111 and 110 give no strobe. The matching strobe is high for exactly the one clock that follows the sampling edge.
- R3: When CS_n is sampled high, no strobe is raised and no bank state changes, whatever the other pins carry.
- R4: An activate to a closed bank sets that bank's open flag and loads its row register with the 14-bit address, and `cmd_bank_o` shows the bank.
- R5: On a read or write, `col_o` shows address bits 9..0 and `auto_pre_o` shows address bit 10, both for the clock after the sampling edge.
- R6: A precharge with address bit 10 low closes only the bank on the bank address. With bit 10 high it closes every bank.
- R7: A mode register set with bank address 0 and address bits 2..0 = 010 selects burst length four. The value 011 selects eight. Any other field value, or any nonzero bank address, leaves the burst length unchanged.
- R8: A read or write with address bit 10 high, sent to an open bank at edge k, closes that bank at edge k+BL. BL is the burst length in force at edge k. The bank stays open after edges k..k+BL-1.
- R9: A read or write to a closed bank sets the sticky flag `err_closed_o`. An activate to an open bank sets the sticky flag `err_reopen_o` and leaves that bank's row register unchanged.
- R10: CKE sampled low after being high enters power-down. `pd_act_o` is set if any bank was open before that edge, and `pd_pre_o` is set otherwise. The flag holds while CKE stays low and clears on the first edge with CKE high. Commands sampled with CKE low are ignored.
- R11: CKE sampled low at any of the BL-1 edges after a read or write edge sets the sticky flag `err_cke_o`. CKE low at edge k+BL does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| ba | input | 3 | Bank address |
| addr | input | 14 | Row, column, auto-precharge bit or op-code |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| mrs_o | output | 1 | Mode register set strobe |
| ref_o | output | 1 | Refresh strobe |
| cmd_bank_o | output | 3 | Bank of the last decoded command |
| col_o | output | 10 | Starting column of the last command |
| auto_pre_o | output | 1 | Auto-precharge request of the last command |
| bl8_o | output | 1 | 1 = burst length eight, 0 = four |
| bank_open_o | output | 8 | Open flag per bank |
| bank_row_o | output | 112 | Row register per bank, bank b at bits 14b+13..14b |
| pd_pre_o | output | 1 | Precharge power-down in effect |
| pd_act_o | output | 1 | Active power-down in effect |
| err_closed_o | output | 1 | Sticky: read/write to a closed bank |
| err_reopen_o | output | 1 | Sticky: activate to an open bank |
| err_cke_o | output | 1 | Sticky: CKE low during a burst |

## Verification
Every strobe, column, auto-precharge bit, open flag, row register, error flag and power-down flag passes through one register. Each result is therefore due in the clock after the edge that sampled the stimulus. The bench drives pins one time unit after a rising edge and checks one time unit after the next edge. Auto-precharge closes are due BL edges after the command. The bench counts idle steps after the command and expects the flag low only at step BL, for both burst lengths. The CKE window is probed at its last forbidden edge and at its first allowed edge.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    C_MRS = 3'b000,
    C_REF = 3'b001,
    C_PRE = 3'b010,
    C_ACT = 3'b011,
    C_WR  = 3'b100,
    C_RD  = 3'b101,
    C_RSV = 3'b110,
    C_NOP = 3'b111
  } cmd_code_e;

  localparam logic [2:0] BL_FIELD_4 = 3'b010;
  localparam logic [2:0] BL_FIELD_8 = 3'b011;

  // deselected parts see a no-operation
  function automatic cmd_code_e decode_cmd(input logic sel_n, input logic [2:0] pins);
    if (sel_n) return C_NOP;
    return cmd_code_e'(pins);
  endfunction

  // clock cycles a burst occupies
  function automatic logic [3:0] burst_beats(input logic long_burst);
    return long_burst ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int BA_W  = 3,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic [2:0]       pins,
  input  logic [BA_W-1:0]  ba,
  input  logic [COL_W-1:0] col_in,
  input  logic             ap_in,
  output logic             ev_act,
  output logic             ev_rd,
  output logic             ev_wr,
  output logic             ev_pre,
  output logic             ev_mrs,
  output logic             ev_ref,
  output logic             act_q,
  output logic             rd_q,
  output logic             wr_q,
  output logic             pre_q,
  output logic             mrs_q,
  output logic             ref_q,
  output logic [BA_W-1:0]  bank_q,
  output logic [COL_W-1:0] col_q,
  output logic             ap_q,
  output logic             bl8_q
);

  cmd_code_e code;
  logic      bl_sel;

  always_comb begin
    code   = decode_cmd(cs_n, pins);
    ev_act = cke && (code == C_ACT);
    ev_rd  = cke && (code == C_RD);
    ev_wr  = cke && (code == C_WR);
    ev_pre = cke && (code == C_PRE);
    ev_mrs = cke && (code == C_MRS);
    ev_ref = cke && (code == C_REF);
    bl_sel = ev_mrs && (ba == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {act_q, rd_q, wr_q, pre_q, mrs_q, ref_q} <= '0;
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      bl8_q  <= 1'b0;
    end else begin
      {act_q, rd_q, wr_q, pre_q, mrs_q, ref_q} <= {ev_act, ev_rd, ev_wr, ev_pre, ev_mrs, ev_ref};
      if (ev_act || ev_rd || ev_wr || ev_pre || ev_mrs || ev_ref) begin
        bank_q <= ba;
        col_q  <= col_in;
        ap_q   <= ap_in;
      end
      if (bl_sel && col_in[2:0] == BL_FIELD_4) bl8_q <= 1'b0;
      else if (bl_sel && col_in[2:0] == BL_FIELD_8) bl8_q <= 1'b1;
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_q, rd_q, wr_q, pre_q, mrs_q, ref_q}));
  p_cs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(act_q || rd_q || wr_q || pre_q || mrs_q || ref_q));
  p_cke_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !(act_q || rd_q || wr_q || pre_q || mrs_q || ref_q));
  p_bl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_mrs |=> $stable(bl8_q));

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 14,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             ev_act,
  input  logic             ev_rdwr,
  input  logic             ap_req,
  input  logic             ev_pre,
  input  logic             pre_all,
  input  logic [ROW_W-1:0] row_in,
  input  logic [CNT_W-1:0] beats,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q,
  output logic             miss_ev,
  output logic             reopen_ev
);

  logic [CNT_W-1:0] ap_cnt;
  logic do_act, ap_load, ap_close, close_pre;

  always_comb begin
    do_act    = hit && ev_act && !open_q;
    reopen_ev = hit && ev_act && open_q;
    miss_ev   = hit && ev_rdwr && !open_q;
    ap_load   = hit && ev_rdwr && open_q && ap_req;
    close_pre = ev_pre && (pre_all || hit);
    ap_close  = (ap_cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      ap_cnt <= '0;
    end else begin
      if (close_pre) open_q <= 1'b0;
      else if (do_act) open_q <= 1'b1;
      else if (ap_close && !ap_load) open_q <= 1'b0;

      if (do_act) row_q <= row_in;

      if (close_pre) ap_cnt <= '0;
      else if (ap_load) ap_cnt <= beats;
      else if (ap_cnt != '0) ap_cnt <= ap_cnt - CNT_W'(1);
    end
  end

  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> open_q && row_q == $past(row_in));
  p_pre_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_pre |=> !open_q);
  p_ap_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_close && !ap_load && !do_act) |=> !open_q);
  p_reopen_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reopen_ev |=> $stable(row_q) && open_q);

endmodule

// File: rtl/sdram_pd_watch.sv
module sdram_pd_watch #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             ev_rdwr,
  input  logic [CNT_W-1:0] beats,
  input  logic             any_open,
  output logic             pd_pre_q,
  output logic             pd_act_q,
  output logic             cke_err_ev
);

  logic [CNT_W-1:0] burst_cnt;
  logic             cke_prev;
  logic             entry;

  always_comb begin
    entry      = cke_prev && !cke;
    cke_err_ev = !cke && (burst_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_cnt <= '0;
      cke_prev  <= 1'b1;
      pd_pre_q  <= 1'b0;
      pd_act_q  <= 1'b0;
    end else begin
      cke_prev <= cke;
      if (ev_rdwr) burst_cnt <= beats - CNT_W'(1);
      else if (burst_cnt != '0) burst_cnt <= burst_cnt - CNT_W'(1);
      if (cke) begin
        pd_pre_q <= 1'b0;
        pd_act_q <= 1'b0;
      end else if (entry) begin
        pd_act_q <= any_open;
        pd_pre_q <= !any_open;
      end
    end
  end

  p_pd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_pre_q && pd_act_q));
  p_pd_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> !pd_pre_q && !pd_act_q);
  p_pd_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && any_open) |=> pd_act_q);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 14,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    act_o,
  output logic                    rd_o,
  output logic                    wr_o,
  output logic                    pre_o,
  output logic                    mrs_o,
  output logic                    ref_o,
  output logic [BA_W-1:0]         cmd_bank_o,
  output logic [COL_W-1:0]        col_o,
  output logic                    auto_pre_o,
  output logic                    bl8_o,
  output logic [NBANK-1:0]        bank_open_o,
  output logic [NBANK*ADDR_W-1:0] bank_row_o,
  output logic                    pd_pre_o,
  output logic                    pd_act_o,
  output logic                    err_closed_o,
  output logic                    err_reopen_o,
  output logic                    err_cke_o
);

  localparam int CNT_W = 4;

  logic ev_act, ev_rd, ev_wr, ev_pre, ev_mrs, ev_ref, ev_rdwr;
  logic [CNT_W-1:0] beats;
  logic [NBANK-1:0] miss_ev, reopen_ev;
  logic cke_err_ev;

  sdram_cmd_decode #(.BA_W(BA_W), .COL_W(COL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .pins({ras_n, cas_n, we_n}), .ba(ba),
    .col_in(addr[COL_W-1:0]), .ap_in(addr[AP_BIT]),
    .ev_act(ev_act), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_pre(ev_pre),
    .ev_mrs(ev_mrs), .ev_ref(ev_ref),
    .act_q(act_o), .rd_q(rd_o), .wr_q(wr_o), .pre_q(pre_o),
    .mrs_q(mrs_o), .ref_q(ref_o),
    .bank_q(cmd_bank_o), .col_q(col_o), .ap_q(auto_pre_o), .bl8_q(bl8_o)
  );

  always_comb begin
    ev_rdwr = ev_rd || ev_wr;
    beats   = burst_beats(bl8_o);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .hit(ba == BA_W'(b)),
      .ev_act(ev_act), .ev_rdwr(ev_rdwr), .ap_req(addr[AP_BIT]),
      .ev_pre(ev_pre), .pre_all(addr[AP_BIT]),
      .row_in(addr), .beats(beats),
      .open_q(bank_open_o[b]),
      .row_q(bank_row_o[b*ADDR_W +: ADDR_W]),
      .miss_ev(miss_ev[b]), .reopen_ev(reopen_ev[b])
    );
  end

  sdram_pd_watch #(.CNT_W(CNT_W)) u_pd (
    .clk(clk), .rst_n(rst_n), .cke(cke), .ev_rdwr(ev_rdwr), .beats(beats),
    .any_open(|bank_open_o),
    .pd_pre_q(pd_pre_o), .pd_act_q(pd_act_o), .cke_err_ev(cke_err_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_closed_o <= 1'b0;
      err_reopen_o <= 1'b0;
      err_cke_o    <= 1'b0;
    end else begin
      if (|miss_ev)   err_closed_o <= 1'b1;
      if (|reopen_ev) err_reopen_o <= 1'b1;
      if (cke_err_ev) err_cke_o    <= 1'b1;
    end
  end

  p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pre && addr[AP_BIT]) |=> (bank_open_o == '0));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_closed_o |=> err_closed_o);
  p_cke_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_cke_o |=> err_cke_o);
  p_cs_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !(|bank_open_o)) |=> !(|bank_open_o));

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010, K_ACT = 3'b011,
                         K_WR = 3'b100, K_RD = 3'b101, K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [13:0] addr = '0;
  logic act_o, rd_o, wr_o, pre_o, mrs_o, ref_o, auto_pre_o, bl8_o;
  logic [2:0] cmd_bank_o;
  logic [9:0] col_o;
  logic [7:0] bank_open_o;
  logic [111:0] bank_row_o;
  logic pd_pre_o, pd_act_o, err_closed_o, err_reopen_o, err_cke_o;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .mrs_o(mrs_o), .ref_o(ref_o),
    .cmd_bank_o(cmd_bank_o), .col_o(col_o), .auto_pre_o(auto_pre_o), .bl8_o(bl8_o),
    .bank_open_o(bank_open_o), .bank_row_o(bank_row_o),
    .pd_pre_o(pd_pre_o), .pd_act_o(pd_act_o),
    .err_closed_o(err_closed_o), .err_reopen_o(err_reopen_o), .err_cke_o(err_cke_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic c, input logic [2:0] code,
                      input logic [2:0] b, input logic [13:0] a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b1, 1'b1, K_NOP, 3'd0, 14'd0);
  endtask

  // strobes packed as {mrs,ref,pre,act,wr,rd}, from the encoding of R2
  function automatic logic [5:0] want_strobe(input logic c, input logic [2:0] code);
    if (c) return 6'b0;
    case (code)
      K_MRS: return 6'b100000;
      K_REF: return 6'b010000;
      K_PRE: return 6'b001000;
      K_ACT: return 6'b000100;
      K_WR:  return 6'b000010;
      K_RD:  return 6'b000001;
      default: return 6'b0;
    endcase
  endfunction

  function automatic logic [13:0] row_of(input int b);
    return 14'(b * 1000 + 5);
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 strobes", {act_o, rd_o, wr_o, pre_o, mrs_o, ref_o}, 0);
    chk("R1 open", bank_open_o, 0);
    chk("R1 rows", (bank_row_o == '0), 1);
    chk("R1 flags", {pd_pre_o, pd_act_o, err_closed_o, err_reopen_o, err_cke_o, bl8_o}, 0);
    rst_n = 1'b1;
    idle();
    chk("R1 after release", {bank_open_o, bl8_o, err_closed_o}, 0);

    // R3 chip select high masks all codes
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 1'b1, 3'(c), 3'd7, 14'h3fff);
      chk("R3 masked strobe", {mrs_o, ref_o, pre_o, act_o, wr_o, rd_o}, 0);
      chk("R3 no state", bank_open_o, 0);
    end

    // R2 decode every code with chip selected, bank 7
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 1'b0, 3'(c), (c == 0) ? 3'd1 : 3'd7, (c == 0) ? 14'h0 : 14'h1234 & 14'h3bff);
      chk("R2 strobe", {mrs_o, ref_o, pre_o, act_o, wr_o, rd_o}, want_strobe(1'b0, 3'(c)));
      idle();
      chk("R2 one cycle", {mrs_o, ref_o, pre_o, act_o, wr_o, rd_o}, 0);
    end
    chk("R4 bank7 open", bank_open_o, 8'h80);
    chk("R9 no errors", {err_closed_o, err_reopen_o}, 0);
    chk("R7 ba1 mrs ignored", bl8_o, 0);

    // R6 precharge all
    step(1'b1, 1'b0, K_PRE, 3'd3, 14'h0400);
    chk("R6 pre all", bank_open_o, 0);

    // R4 activate sweep over banks
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 1'b0, K_ACT, 3'(b), row_of(b));
      chk("R4 act strobe", act_o, 1);
      chk("R4 cmd bank", cmd_bank_o, b);
      chk("R4 open bit", bank_open_o[b], 1);
      chk("R4 row", bank_row_o[b*14 +: 14], row_of(b));
    end
    chk("R4 all open", bank_open_o, 8'hff);

    // R5 read column and auto-precharge bit
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 1'b0, K_RD, 3'(b), 14'((b * 37 + 3) & 10'h3ff) | 14'h2800);
      chk("R5 column", col_o, (b * 37 + 3) & 10'h3ff);
      chk("R5 no ap", auto_pre_o, 0);
      chk("R5 bank", cmd_bank_o, b);
    end
    step(1'b1, 1'b0, K_WR, 3'd4, 14'h0000);
    chk("R5 write strobe", wr_o, 1);

    // R6 single bank precharge
    step(1'b1, 1'b0, K_PRE, 3'd3, 14'h3bff);
    chk("R6 single bank", bank_open_o, 8'hf7);
    step(1'b1, 1'b0, K_PRE, 3'd0, 14'h0400);
    chk("R6 all closed", bank_open_o, 0);

    // R8 auto-precharge with burst four
    step(1'b1, 1'b0, K_ACT, 3'd2, 14'd77);
    step(1'b1, 1'b0, K_RD, 3'd2, 14'h0405);
    chk("R5 ap bit", auto_pre_o, 1);
    chk("R5 ap column", col_o, 5);
    chk("R8 open at k", bank_open_o[2], 1);
    for (int j = 1; j <= 4; j++) begin
      idle();
      chk("R8 bl4 close timing", bank_open_o[2], (j < 4) ? 1 : 0);
    end

    // R7 burst length programming
    step(1'b1, 1'b0, K_MRS, 3'd0, 14'h0003);
    chk("R7 set eight", bl8_o, 1);
    step(1'b1, 1'b0, K_MRS, 3'd2, 14'h0002);
    chk("R7 extended reg ignored", bl8_o, 1);
    step(1'b1, 1'b0, K_MRS, 3'd0, 14'h0005);
    chk("R7 other field ignored", bl8_o, 1);

    // R8 auto-precharge with burst eight on a write
    step(1'b1, 1'b0, K_ACT, 3'd5, 14'd99);
    step(1'b1, 1'b0, K_WR, 3'd5, 14'h0400);
    for (int j = 1; j <= 8; j++) begin
      idle();
      chk("R8 bl8 close timing", bank_open_o[5], (j < 8) ? 1 : 0);
    end
    step(1'b1, 1'b0, K_MRS, 3'd0, 14'h0002);
    chk("R7 back to four", bl8_o, 0);

    // R11 CKE low just after the burst window, no error
    step(1'b1, 1'b0, K_ACT, 3'd0, 14'd11);
    step(1'b1, 1'b0, K_RD, 3'd0, 14'd0);
    for (int j = 1; j <= 3; j++) idle();
    step(1'b0, 1'b1, K_NOP, 3'd0, 14'd0);
    chk("R11 edge k+BL allowed", err_cke_o, 0);
    chk("R10 active pd", {pd_act_o, pd_pre_o}, 2'b10);
    // R10 command ignored while CKE low
    step(1'b0, 1'b0, K_ACT, 3'd4, 14'd55);
    chk("R10 act ignored", {act_o, bank_open_o[4]}, 0);
    chk("R10 pd held", pd_act_o, 1);
    step(1'b1, 1'b1, K_NOP, 3'd0, 14'd0);
    chk("R10 pd exit", {pd_act_o, pd_pre_o}, 0);
    step(1'b1, 1'b0, K_PRE, 3'd0, 14'h0400);
    step(1'b0, 1'b1, K_NOP, 3'd0, 14'd0);
    chk("R10 precharge pd", {pd_act_o, pd_pre_o}, 2'b01);
    idle();
    chk("R10 pd exit 2", {pd_act_o, pd_pre_o}, 0);

    // R11 CKE low inside the window
    step(1'b1, 1'b0, K_ACT, 3'd0, 14'd11);
    step(1'b1, 1'b0, K_RD, 3'd0, 14'd0);
    idle();
    idle();
    step(1'b0, 1'b1, K_NOP, 3'd0, 14'd0);
    chk("R11 last window edge", err_cke_o, 1);
    idle();

    // R9 error flags
    chk("R9 clean before", {err_closed_o, err_reopen_o}, 0);
    step(1'b1, 1'b0, K_RD, 3'd6, 14'h0400);
    chk("R9 closed access", err_closed_o, 1);
    step(1'b1, 1'b0, K_ACT, 3'd1, 14'd100);
    step(1'b1, 1'b0, K_ACT, 3'd1, 14'd200);
    chk("R9 reopen flag", err_reopen_o, 1);
    chk("R9 row kept", bank_row_o[14 +: 14], 100);
    idle();
    chk("R9 sticky", {err_closed_o, err_reopen_o}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule